// File: doc/BRIEF.md
# Default Queue Configuration Sequencer

After a synchronous reset, this block fills the setup registers of a multi-queue buffer manager with default values. It creates the largest supported number of queues. The buffer memory is divided into equal segments, one per queue. For each queue the block issues one write on its configuration port. That write carries the queue index, the first address, the last address and the segment size. The register file that receives the writes sits outside the block.

Several devices can be configured in turn. Each device has an active-low turn input and an active-low done output, and the done output of one device drives the turn input of the next. The first device in the chain may have its turn input tied low. A device writes only while its turn input is low. When it has written its last queue, its done output falls. The falling edge of the last device's done output marks the point where normal traffic may start for the whole chain.

Top module: `qcfg_default_loader`

## Requirements
- R1: While reset is high at a clock edge, the outputs after that edge are `chain_done_n` = 1 and `cfg_we` = 0. After reset, configuration restarts from queue 0.
- R2: A write happens only at an edge where `default_mode` = 1 and `chain_in_n` = 0. The write port shows that write in the cycle after the edge.
- R3: Writes go one queue per clock, in ascending order from 0 to NUM_Q-1, and no index is skipped or repeated.
- R4: With SEG = DEPTH/NUM_Q, the write for queue k carries base = k*SEG, end = k*SEG+SEG-1 and size = SEG.
- R5: At an edge where `chain_in_n` = 1 or `default_mode` = 0 before completion, no write takes place. The next index is held, and writing resumes from that index.
- R6: `chain_done_n` falls on the edge after the one that issued the write for queue NUM_Q-1. It then stays low until reset, and no further writes occur, whatever the inputs do.
- R7: While `default_mode` = 0, the block stays idle: `chain_done_n` = 1 and `cfg_we` = 0.
- R8: A reset during configuration abandons it. The next run starts again at queue 0 with `chain_done_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| default_mode | input | 1 | 1 selects default configuration |
| chain_in_n | input | 1 | Active-low turn from the previous device |
| chain_done_n | output | 1 | Active-low completion, drives the next device's turn input |
| cfg_we | output | 1 | Configuration write strobe |
| cfg_idx | output | $clog2(NUM_Q) | Queue index being written |
| cfg_base | output | $clog2(DEPTH) | First buffer address of the queue |
| cfg_end | output | $clog2(DEPTH) | Last buffer address of the queue |
| cfg_size | output | $clog2(DEPTH)+1 | Segment size in words |

## Verification
The assertions assume that `default_mode` and `chain_in_n` change only between clock edges. They also assume that reset is held for at least two edges at start-up, so that every `$past` term sees reset values. The bench changes its inputs only on the falling clock edge and holds reset for several cycles. It stops the chain turn part way through, drops the mode select part way through, and applies a single-cycle reset in the middle of a run. After completion it toggles both inputs, so the assertions are exercised near their boundaries and never outside what they assume.

// File: rtl/qcfg_pkg.sv
package qcfg_pkg;
  typedef enum logic [0:0] {
    ST_LOAD = 1'b0,
    ST_FIN  = 1'b1
  } qcfg_state_t;
endpackage

// File: rtl/qcfg_seg_calc.sv
module qcfg_seg_calc #(
  parameter int NUM_Q = 32,
  parameter int DEPTH = 4096,
  localparam int QW  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int AW  = $clog2(DEPTH),
  localparam int SEG = DEPTH / NUM_Q
) (
  input  logic [QW-1:0] idx,
  output logic [AW-1:0] base,
  output logic [AW-1:0] last
);
  localparam logic [AW-1:0] SEG_A = AW'(SEG);
  localparam bit SEG_POW2 = ((SEG & (SEG - 1)) == 0);

  logic [AW-1:0] idx_ext;
  assign idx_ext = AW'(idx);

  // A power-of-two segment needs only a shift; any other size needs a multiplier.
  generate
    if (SEG_POW2) begin : g_shift
      localparam int SH = $clog2(SEG);
      assign base = idx_ext << SH;
    end else begin : g_mult
      assign base = idx_ext * SEG_A;
    end
  endgenerate

  assign last = base + SEG_A - AW'(1);
endmodule

// File: rtl/qcfg_seq.sv
module qcfg_seq
  import qcfg_pkg::*;
#(
  parameter int NUM_Q = 32,
  parameter int DEPTH = 4096,
  localparam int QW  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int AW  = $clog2(DEPTH),
  localparam int SW  = AW + 1,
  localparam int SEG = DEPTH / NUM_Q
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          default_mode,
  input  logic          chain_in_n,
  input  logic [AW-1:0] calc_base,
  input  logic [AW-1:0] calc_last,
  output logic [QW-1:0] cnt,
  output logic          chain_done_n,
  output logic          cfg_we,
  output logic [QW-1:0] cfg_idx,
  output logic [AW-1:0] cfg_base,
  output logic [AW-1:0] cfg_end,
  output logic [SW-1:0] cfg_size
);
  localparam logic [QW-1:0] LAST_Q = QW'(NUM_Q - 1);
  localparam logic [AW-1:0] SEG_A  = AW'(SEG);

  qcfg_state_t st;
  logic        step;

  assign step = default_mode & ~chain_in_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_LOAD;
      cnt          <= '0;
      chain_done_n <= 1'b1;
      cfg_we       <= 1'b0;
      cfg_idx      <= '0;
      cfg_base     <= '0;
      cfg_end      <= '0;
      cfg_size     <= '0;
    end else begin
      case (st)
        ST_LOAD: begin
          cfg_we <= 1'b0;
          if (step) begin
            cfg_we   <= 1'b1;
            cfg_idx  <= cnt;
            cfg_base <= calc_base;
            cfg_end  <= calc_last;
            cfg_size <= SW'(SEG);
            if (cnt == LAST_Q) st <= ST_FIN;
            else               cnt <= cnt + QW'(1);
          end
        end
        ST_FIN: begin
          cfg_we       <= 1'b0;
          chain_done_n <= 1'b0;
        end
        default: st <= ST_LOAD;
      endcase
    end
  end

  // R1: reset drives the idle outputs
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (chain_done_n && !cfg_we));

  // R5: no write after an edge where the turn is withheld
  p_pause_r5: assert property (@(posedge clk) disable iff (rst)
    chain_in_n |=> !cfg_we);

  // R7: mode select low blocks writes
  p_idle_mode_r7: assert property (@(posedge clk) disable iff (rst)
    !default_mode |=> !cfg_we);

  // R3: back-to-back writes step the index by one
  p_index_step_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && $past(cfg_we)) |-> (cfg_idx == $past(cfg_idx) + QW'(1)));

  // R4: address fields match the segment of the written queue
  p_segment_r4: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> ((cfg_base == AW'(cfg_idx) * SEG_A) &&
                (cfg_end - cfg_base == SEG_A - AW'(1))));

  // R6: completion follows the last write and then holds
  p_done_after_last_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(chain_done_n) |-> ($past(cfg_we) && ($past(cfg_idx) == LAST_Q)));

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    !chain_done_n |=> !chain_done_n);

  p_quiet_after_done_r6: assert property (@(posedge clk) disable iff (rst)
    !chain_done_n |-> !cfg_we);
endmodule

// File: rtl/qcfg_default_loader.sv
module qcfg_default_loader #(
  parameter int NUM_Q = 32,
  parameter int DEPTH = 4096,
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          default_mode,
  input  logic          chain_in_n,
  output logic          chain_done_n,
  output logic          cfg_we,
  output logic [QW-1:0] cfg_idx,
  output logic [AW-1:0] cfg_base,
  output logic [AW-1:0] cfg_end,
  output logic [SW-1:0] cfg_size
);
  logic [QW-1:0] cnt;
  logic [AW-1:0] calc_base;
  logic [AW-1:0] calc_last;

  qcfg_seg_calc #(.NUM_Q(NUM_Q), .DEPTH(DEPTH)) u_calc (
    .idx  (cnt),
    .base (calc_base),
    .last (calc_last)
  );

  qcfg_seq #(.NUM_Q(NUM_Q), .DEPTH(DEPTH)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .default_mode (default_mode),
    .chain_in_n   (chain_in_n),
    .calc_base    (calc_base),
    .calc_last    (calc_last),
    .cnt          (cnt),
    .chain_done_n (chain_done_n),
    .cfg_we       (cfg_we),
    .cfg_idx      (cfg_idx),
    .cfg_base     (cfg_base),
    .cfg_end      (cfg_end),
    .cfg_size     (cfg_size)
  );
endmodule

// File: tb/tb_qcfg_default_loader.sv
`timescale 1ns/1ps
module tb_qcfg_default_loader;
  localparam int NQ  = 8;
  localparam int DP  = 256;
  localparam int SEG = DP / NQ;
  localparam int QW  = $clog2(NQ);
  localparam int AW  = $clog2(DP);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic default_mode = 1'b1;
  logic chain_in_n = 1'b1;
  logic chain_done_n, cfg_we;
  logic [QW-1:0] cfg_idx;
  logic [AW-1:0] cfg_base, cfg_end;
  logic [AW:0]   cfg_size;

  qcfg_default_loader #(.NUM_Q(NQ), .DEPTH(DP)) dut (
    .clk(clk), .rst(rst), .default_mode(default_mode), .chain_in_n(chain_in_n),
    .chain_done_n(chain_done_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_end(cfg_end), .cfg_size(cfg_size)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string phase = "R1";

  // reference model state
  int  m_next = 0;
  bit  m_fin = 0;
  bit  m_we = 0;
  bit  m_done_n = 1;
  int  m_idx = 0;
  int  writes_seen = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_next = 0; m_fin = 0; m_we = 0; m_done_n = 1;
    end else if (m_fin) begin
      m_we = 0; m_done_n = 0;
    end else if (default_mode && !chain_in_n) begin
      m_we = 1; m_idx = m_next;
      if (m_next == NQ - 1) m_fin = 1;
      m_next = m_next + 1;
    end else begin
      m_we = 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compare on every falling edge, before new inputs are driven
  always @(negedge clk) begin
    if (!finished) begin
      chk((phase == "R6") ? "R6" : phase, "chain_done_n", int'(chain_done_n), int'(m_done_n));
      chk((phase == "R5" || phase == "R7") ? phase : "R2", "cfg_we", int'(cfg_we), int'(m_we));
      if (m_we && cfg_we) begin
        writes_seen++;
        chk("R3", "cfg_idx", int'(cfg_idx), m_idx);
        chk("R4", "cfg_base", int'(cfg_base), m_idx * SEG);
        chk("R4", "cfg_end", int'(cfg_end), m_idx * SEG + SEG - 1);
        chk("R4", "cfg_size", int'(cfg_size), SEG);
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    phase = "R1";
    cyc(4);
    rst = 1'b0;
    cyc(3);
    // R7: mode low keeps the block idle even with the turn granted
    phase = "R7";
    default_mode = 1'b0; chain_in_n = 1'b0;
    cyc(5);
    // R2: start once mode is high and the turn is low
    phase = "R2";
    default_mode = 1'b1;
    cyc(3);
    // R5: pause by withdrawing the turn, then by dropping the mode
    phase = "R5";
    chain_in_n = 1'b1;
    cyc(3);
    chain_in_n = 1'b0; default_mode = 1'b0;
    cyc(2);
    // R3: resume to completion
    phase = "R3";
    default_mode = 1'b1;
    cyc(NQ);
    // R6: done holds while the inputs move
    phase = "R6";
    for (int i = 0; i < 6; i++) begin
      chain_in_n = i[0]; default_mode = i[1];
      cyc(1);
    end
    chk("R6", "done stays low", int'(chain_done_n), 0);
    // R8: reset mid-run, then a full run from queue 0
    phase = "R8";
    default_mode = 1'b1; chain_in_n = 1'b0;
    rst = 1'b1; cyc(1); rst = 1'b0;
    chk("R1", "done after reset", int'(chain_done_n), 1);
    cyc(3);
    rst = 1'b1; cyc(1); rst = 1'b0;
    chk("R8", "done high after mid reset", int'(chain_done_n), 1);
    cyc(NQ + 3);
    chk("R8", "done after rerun", int'(chain_done_n), 0);
    chk("R3", "writes observed", writes_seen > 2 * NQ ? 1 : 0, 1);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule